// File: doc/BRIEF.md
# Dual-Slot Speculative Flag Synchronizer

This block brings a FIFO's not-empty level into the receive clock domain with about one cycle of latency. It does not wait out a long settling window before reporting. Each flag bit is sampled early and presented at once as data-available. The same bit is sampled again one receive edge later. If the bit was low at the early sample and high at the late one, the early answer may have been taken while the first stage was unresolved. The block then raises a fail flag for that earlier cycle, and the consumer repeats the transfer.

The late check lands inside the cycle that follows the speculation. For that reason, two sampling slots take turns by cycle parity. The slot that speculated in one cycle keeps its early sample through the next cycle, where its late sample is taken. Meanwhile the other slot speculates on the new cycle. A data-available mux follows the current parity, and a fail mux follows the opposite parity.

Both flags are plain level signals, so no valid/ready handshake applies and nothing exerts back-pressure. The consumer treats fail during cycle k as a veto of the data-available it was shown during cycle k-1.

Top module: `spec_flag_sync`

## Requirements
- R1: During the cycle after receive edge k, each data-available bit equals the corresponding not-empty bit sampled at edge k.
- R2: A fail bit refers to the previous cycle. During the cycle after edge k, fail bit i is 1 exactly when input bit i was 0 at edge k-1 and 1 at edge k. It is never raised against the cycle in which that data-available is shown.
- R3: An input bit that is 1 at edge k-1 and 0 at edge k produces fail 0 and data-available 0.
- R4: An input bit held steady, high or low, over consecutive edges produces fail 0.
- R5: An internal parity toggles on every receive edge and resets to even. Odd-parity cycles are sampled by one slot and even-parity cycles by the other, so rises in back-to-back cycles are each flagged.
- R6: A slot's early sample is held unchanged through the following cycle while its late sample is taken. A new cycle never overwrites it.
- R7: Data-available is taken from the slot of the current parity, and fail from the slot of the previous parity.
- R8: While reset is low (asynchronous, active low), both outputs are 0 and all samples are cleared. After release, the early sample of the cycle before the first edge counts as 0.
- R9: Flag bits are synchronized independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ne_in | input | FLAGS | Not-empty level(s) from the writer side |
| da_out | output | FLAGS | Speculative data-available for the current cycle |
| fail_out | output | FLAGS | Fail for the previous cycle's data-available |

## Verification
Some properties are checked on every cycle by assertions:
- the parity alternates on every edge;
- exactly one slot loads an early sample per edge;
- a slot's early sample stays fixed during its check cycle;
- a fail bit never appears unless the previous cycle showed data-available low and the current one shows it high;
- reset forces both outputs low.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle in which fail and data-available appear for rising, falling and steady inputs;
- back-to-back rises on alternating slots;
- independence of the flag bits;
- the cleared history after a reset in the middle of a run.

// File: rtl/spec_sync_pkg.sv
package spec_sync_pkg;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;

  localparam int unsigned NUM_SLOTS = 2;
endpackage

// File: rtl/spec_parity_gen.sv
module spec_parity_gen
  import spec_sync_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  output parity_e par_q,
  output parity_e par_next
);
  always_comb par_next = (par_q == PAR_EVEN) ? PAR_ODD : PAR_EVEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= PAR_EVEN;
    else        par_q <= par_next;
  end

  // R5: parity alternates on every receive edge
  a_r5_parity_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> par_q != $past(par_q));
endmodule

// File: rtl/spec_slot.sv
module spec_slot #(
  parameter int unsigned FLAGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_early,
  input  logic             ld_late,
  input  logic [FLAGS-1:0] ne,
  output logic [FLAGS-1:0] early_q,
  output logic [FLAGS-1:0] fail_q
);
  logic [FLAGS-1:0] late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= '0;
      late_q  <= '0;
    end else begin
      if (ld_early) early_q <= ne;
      if (ld_late)  late_q  <= ne;
    end
  end

  // Late sample high while the early one was low: the speculation may be wrong
  always_comb fail_q = late_q & ~early_q;

  // R6: the early sample is held while the late sample is taken
  a_r6_hold_early: assert property (@(posedge clk) disable iff (!rst_n)
    ld_late |=> early_q == $past(early_q));

  // R5: a slot never speculates and checks on the same edge
  a_r5_single_role: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_early && ld_late));
endmodule

// File: rtl/spec_flag_sync.sv
module spec_flag_sync
  import spec_sync_pkg::*;
#(
  parameter int unsigned FLAGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLAGS-1:0] ne_in,
  output logic [FLAGS-1:0] da_out,
  output logic [FLAGS-1:0] fail_out
);
  localparam int unsigned SEL_W = $clog2(NUM_SLOTS);

  parity_e par_q;
  parity_e par_next;

  logic [FLAGS-1:0] early_arr [NUM_SLOTS];
  logic [FLAGS-1:0] fail_arr  [NUM_SLOTS];

  spec_parity_gen u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_q    (par_q),
    .par_next (par_next)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic ld_e;
    logic ld_l;
    always_comb begin
      ld_e = (SEL_W'(par_next) == SEL_W'(g));
      ld_l = (SEL_W'(par_q)    == SEL_W'(g));
    end
    spec_slot #(.FLAGS(FLAGS)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_early (ld_e),
      .ld_late  (ld_l),
      .ne       (ne_in),
      .early_q  (early_arr[g]),
      .fail_q   (fail_arr[g])
    );
  end

  // R7: data-available follows the current parity, fail follows the previous one
  logic sel_da;
  logic sel_fail;
  always_comb begin
    sel_da   = par_q;
    sel_fail = ~par_q;
    da_out   = early_arr[sel_da];
    fail_out = fail_arr[sel_fail];
  end

  for (genvar b = 0; b < FLAGS; b++) begin : g_chk
    // R2: a fail needs a low data-available in the previous cycle
    a_r2_fail_prev_low: assert property (@(posedge clk) disable iff (!rst_n)
      fail_out[b] |-> !$past(da_out[b]));
    // R3: a fail is only raised on a rise, so the new cycle shows the bit high
    a_r3_fail_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      fail_out[b] |-> da_out[b]);
  end

  // R8: outputs are low while reset is held
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (da_out == '0 && fail_out == '0));
endmodule

// File: tb/sim_spec_flag_sync.sv
module sim_spec_flag_sync;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ne_in;
  logic [1:0] da_out;
  logic [1:0] fail_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spec_flag_sync #(.FLAGS(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ne_in    (ne_in),
    .da_out   (da_out),
    .fail_out (fail_out)
  );

  // Each entry: {ne driven before edge k, expected da after k, expected fail after k}
  localparam int NV = 13;
  localparam logic [5:0] VEC [NV] = '{
    6'b00_00_00, 6'b01_01_01, 6'b01_01_00, 6'b11_11_10,
    6'b10_10_00, 6'b00_00_00, 6'b11_11_11, 6'b11_11_00,
    6'b00_00_00, 6'b10_10_10, 6'b10_10_00, 6'b01_01_01,
    6'b00_00_00
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] ne, input logic [1:0] e_da,
                      input logic [1:0] e_fail, input string req);
    ne_in = ne;
    @(negedge clk);
    chk({req, " da"}, da_out, e_da);
    chk({req, " fail"}, fail_out, e_fail);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ne_in = 2'b11;
    repeat (2) @(negedge clk);
    chk("R8 reset da", da_out, 2'b00);
    chk("R8 reset fail", fail_out, 2'b00);
    rst_n = 1'b1;

    // Table walk: R1 sampling, R2 fail timing, R3 falls, R9 independent bits
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5:4], VEC[i][3:2], VEC[i][1:0], $sformatf("R1/R2/R3/R9 vec%0d", i));
    end

    // R4: steady high raises fail once, then never again
    step(2'b11, 2'b11, 2'b11, "R2 rise");
    step(2'b11, 2'b11, 2'b00, "R4 steady high");
    step(2'b11, 2'b11, 2'b00, "R4 steady high");
    step(2'b00, 2'b00, 2'b00, "R3 fall");
    step(2'b00, 2'b00, 2'b00, "R4 steady low");

    // R5/R7: rises in back-to-back cycles land on alternating slots
    step(2'b01, 2'b01, 2'b01, "R5 rise slot A");
    step(2'b11, 2'b11, 2'b10, "R5 rise slot B");
    step(2'b11, 2'b11, 2'b00, "R7 quiet");

    // R8: a reset in the middle of a run clears outputs and history
    rst_n = 1'b0;
    #1;
    chk("R8 async da", da_out, 2'b00);
    chk("R8 async fail", fail_out, 2'b00);
    @(negedge clk);
    chk("R8 held da", da_out, 2'b00);
    rst_n = 1'b1;
    step(2'b11, 2'b11, 2'b11, "R8 cleared history");

    // R6: the early low sample survives the next edge, so the rise is flagged
    step(2'b00, 2'b00, 2'b00, "R6 low");
    step(2'b10, 2'b10, 2'b10, "R6 held early");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule